// File: doc/BRIEF.md
# Banked Address Decoder with Boot Overlay

This block sits beside a processor that drives a 16-bit address and time-multiplexes the upper address byte (the bank) on its data bus during the low half of the phase-2 clock. The block captures that bank byte, forms a 24-bit address from it, and turns each bus cycle into active-low select lines. These lines are output and write enables for each memory module group, a shared row of chip enables inside the selected module, a ROM enable, and one select for each of a small number of 32 KiB peripheral windows.

A memory or ROM select is asserted only in a cycle that the processor marks as valid through its valid-data or valid-program-address strobe. Peripheral selects use the valid-data strobe alone. This means an opcode or operand fetch that only touches the address bus never selects a peripheral. After reset, a boot overlay hides the RAM in bank 0x00 and places ROM there for reads. A data-strobed write of 0 to one fixed control address removes the overlay, and a write of 1 restores it.

All pins are plain control levels. There is no streaming data path and no handshake, so no valid/ready rules apply. The processor strobes act as the only qualifiers.

Top module: `bank_addr_decoder`

## Requirements
- R1: While `phi2` is low, each rising `clk` edge loads `bus_d` into the bank register. While `phi2` is high, the bank register keeps its value whatever `bus_d` does. The 24-bit address is {bank, `addr`}.
- R2: Address bits 23:22 give the group. Group values 0, 1 and 2 are memory module groups that own `grp_oe_n[g]`/`grp_we_n[g]`. Group value 3 is I/O space and never drives a memory enable.
- R3: For a valid memory cycle, a read (`rw`=1) pulls low only `grp_oe_n[group]` and leaves every `grp_we_n` high. A write (`rw`=0) never pulls any `grp_oe_n` low.
- R4: A `grp_we_n` line goes low only while `phi2` is high. In a valid write with `phi2` low, all write enables stay high.
- R5: For a valid memory cycle, `chip_ce_n[i]` goes low for i equal to address bits 21:19. At most one chip enable is low in any cycle.
- R6: When both `vda` and `vpa` are 0, all memory enables, chip enables and `rom_ce_n` stay high.
- R7: In group 3, address bits 21:15 give a 32 KiB block index k. `io_sel_n[k]` goes low for k below 4 only when `vda` is 1. `vpa` alone selects no window.
- R8: Reset turns the overlay on. While it is on, a valid access to bank 0x00 asserts no RAM enable or chip enable. A read of bank 0x00 asserts `rom_ce_n`, and a write of bank 0x00 asserts nothing. Other banks are unaffected.
- R9: A write (`rw`=0, `vda`=1, `phi2` high) to address 0xFFFFF0 loads `bus_d[0]` into the overlay bit at the next `clk` edge (1 = on, 0 = off). The same write with only `vpa` set leaves the overlay bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than phase-2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor phase-2 clock level |
| bus_d | input | 8 | Processor data bus (bank byte while phi2 low) |
| addr | input | 16 | Processor address bits 15:0 |
| rw | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Valid data address strobe |
| vpa | input | 1 | Valid program address strobe |
| grp_oe_n | output | 3 | Output enable per memory group, active low |
| grp_we_n | output | 3 | Write enable per memory group, active low |
| chip_ce_n | output | 8 | Chip enable inside the selected module, active low |
| rom_ce_n | output | 1 | Boot ROM enable, active low |
| io_sel_n | output | 4 | Peripheral window selects, active low |

## Verification
The bank byte goes through one register, so it is usable one `clk` edge after it appears with `phi2` low. All selects are combinational from that register and the live bus pins, so they are valid in the same cycle the address and strobes are driven. The overlay bit changes one edge after a control write. The bench therefore drives inputs on the falling edge, lets one rising edge pass for each bank capture or control write, and samples 2 ns after the next falling-edge drive. Its expected values come from the address fields for all 256 banks, both values of bit 15, all four strobe pairs and both directions, with the overlay on and again with it off.

// File: rtl/bad_pkg.sv
`timescale 1ns/1ps
package bad_pkg;
  localparam int BANK_W   = 8;
  localparam int ADDR_W   = 16;
  localparam int FULL_W   = BANK_W + ADDR_W;
  localparam int GRP_W    = 2;
  localparam int CHIP_W   = 3;
  localparam int GRP_LSB  = FULL_W - GRP_W;
  localparam int CHIP_LSB = GRP_LSB - CHIP_W;

  typedef logic [FULL_W-1:0] full_addr_t;

  typedef struct packed {
    logic rd;         // 1 = read cycle
    logic mem_valid;  // vda | vpa
    logic io_valid;   // vda only
  } cyc_t;
endpackage

// File: rtl/bank_capture.sv
`timescale 1ns/1ps
module bank_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phi2,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= '0;
    else if (!phi2) bank_q <= bus_in;
  end

  assert_load_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |=> bank_q == $past(bus_in));
  assert_hold_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phi2 |=> $stable(bank_q));
endmodule

// File: rtl/mem_select.sv
`timescale 1ns/1ps
module mem_select
  import bad_pkg::*;
#(
  parameter int MEM_GROUPS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  phi2,
  input  logic [GRP_W-1:0]      grp,
  input  logic [CHIP_W-1:0]     chip,
  input  cyc_t                  cyc,
  input  logic                  block_ram,
  output logic [MEM_GROUPS-1:0] oe_n,
  output logic [MEM_GROUPS-1:0] we_n,
  output logic [(1<<CHIP_W)-1:0] ce_n
);
  localparam int CHIPS = 1 << CHIP_W;

  logic mem_on;
  assign mem_on = cyc.mem_valid && (int'(grp) < MEM_GROUPS) && !block_ram;

  for (genvar g = 0; g < MEM_GROUPS; g++) begin : g_grp
    assign oe_n[g] = !(mem_on &&  cyc.rd         && grp == GRP_W'(g));
    assign we_n[g] = !(mem_on && !cyc.rd && phi2 && grp == GRP_W'(g));
  end

  for (genvar i = 0; i < CHIPS; i++) begin : g_chip
    assign ce_n[i] = !(mem_on && chip == CHIP_W'(i));
  end

  assert_one_chip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);
  assert_we_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> &we_n);
  assert_rw_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !((&oe_n) == 1'b0 && (&we_n) == 1'b0));
endmodule

// File: rtl/io_select.sv
`timescale 1ns/1ps
module io_select
  import bad_pkg::*;
#(
  parameter int NUM_IO   = 4,
  parameter int IO_GROUP = 3,
  parameter int BLK_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  grp,
  input  logic [BLK_W-1:0]  blk,
  input  logic              io_valid,
  output logic [NUM_IO-1:0] sel_n
);
  logic in_io;
  assign in_io = io_valid && grp == GRP_W'(IO_GROUP);

  for (genvar k = 0; k < NUM_IO; k++) begin : g_win
    assign sel_n[k] = !(in_io && blk == BLK_W'(k));
  end

  assert_one_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));
endmodule

// File: rtl/boot_overlay.sv
`timescale 1ns/1ps
module boot_overlay
  import bad_pkg::*;
#(
  parameter full_addr_t CTRL_ADDR = 24'hFF_FFF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phi2,
  input  full_addr_t full,
  input  cyc_t       cyc,
  input  logic       wr_bit,
  output logic       overlay_on
);
  logic ctrl_wr;
  assign ctrl_wr = cyc.io_valid && !cyc.rd && phi2 && full == CTRL_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overlay_on <= 1'b1;
    else if (ctrl_wr) overlay_on <= wr_bit;
  end

  assert_ctrl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> overlay_on == $past(wr_bit));
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(overlay_on));
endmodule

// File: rtl/bank_addr_decoder.sv
`timescale 1ns/1ps
module bank_addr_decoder
  import bad_pkg::*;
#(
  parameter int         MEM_GROUPS = 3,
  parameter int         NUM_IO     = 4,
  parameter int         IO_BLK_LSB = 15,
  parameter full_addr_t CTRL_ADDR  = 24'hFF_FFF0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   phi2,
  input  logic [BANK_W-1:0]      bus_d,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   rw,
  input  logic                   vda,
  input  logic                   vpa,
  output logic [MEM_GROUPS-1:0]  grp_oe_n,
  output logic [MEM_GROUPS-1:0]  grp_we_n,
  output logic [(1<<CHIP_W)-1:0] chip_ce_n,
  output logic                   rom_ce_n,
  output logic [NUM_IO-1:0]      io_sel_n
);
  localparam int BLK_W    = GRP_LSB - IO_BLK_LSB;
  localparam int IO_GROUP = (1 << GRP_W) - 1;

  logic [BANK_W-1:0] bank_q;
  logic              overlay_on;
  logic              bank0_hit;
  full_addr_t        full;
  cyc_t              cyc;

  assign full          = {bank_q, addr};
  assign cyc.rd        = rw;
  assign cyc.mem_valid = vda | vpa;
  assign cyc.io_valid  = vda;
  assign bank0_hit     = overlay_on && bank_q == '0;
  assign rom_ce_n      = !(cyc.mem_valid && bank0_hit && rw);

  bank_capture #(.W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .bus_in(bus_d), .bank_q(bank_q));

  boot_overlay #(.CTRL_ADDR(CTRL_ADDR)) u_ovl (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .full(full), .cyc(cyc),
    .wr_bit(bus_d[0]), .overlay_on(overlay_on));

  mem_select #(.MEM_GROUPS(MEM_GROUPS)) u_mem (
    .clk(clk), .rst_n(rst_n), .phi2(phi2),
    .grp(full[FULL_W-1:GRP_LSB]), .chip(full[GRP_LSB-1:CHIP_LSB]),
    .cyc(cyc), .block_ram(bank0_hit),
    .oe_n(grp_oe_n), .we_n(grp_we_n), .ce_n(chip_ce_n));

  io_select #(.NUM_IO(NUM_IO), .IO_GROUP(IO_GROUP), .BLK_W(BLK_W)) u_io (
    .clk(clk), .rst_n(rst_n),
    .grp(full[FULL_W-1:GRP_LSB]), .blk(full[GRP_LSB-1:IO_BLK_LSB]),
    .io_valid(cyc.io_valid), .sel_n(io_sel_n));

  assert_rom_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n |-> (&chip_ce_n && &grp_oe_n && &grp_we_n));
  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!vda && !vpa) |-> (&chip_ce_n && rom_ce_n && &io_sel_n));
  assert_io_vda_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vda |-> &io_sel_n);
endmodule

// File: tb/bank_addr_decoder_tb.sv
`timescale 1ns/1ps
module bank_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b0;
  logic [7:0]  bus_d = '0;
  logic [15:0] addr = '0;
  logic        rw = 1'b1, vda = 1'b0, vpa = 1'b0;
  logic [2:0]  grp_oe_n, grp_we_n;
  logic [7:0]  chip_ce_n;
  logic        rom_ce_n;
  logic [3:0]  io_sel_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bank_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .bus_d(bus_d), .addr(addr),
    .rw(rw), .vda(vda), .vpa(vpa), .grp_oe_n(grp_oe_n), .grp_we_n(grp_we_n),
    .chip_ce_n(chip_ce_n), .rom_ce_n(rom_ce_n), .io_sel_n(io_sel_n));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // low phase: put bank on the bus, one rising edge loads it (R1)
  task automatic load_bank(logic [7:0] b);
    @(negedge clk);
    phi2 = 1'b0; vda = 0; vpa = 0; rw = 1; bus_d = b;
    @(posedge clk);
  endtask

  task automatic drive_high(logic [15:0] a, logic r, logic d, logic p, logic [7:0] dat);
    @(negedge clk);
    phi2 = 1'b1; addr = a; rw = r; vda = d; vpa = p; bus_d = dat;
    #2;
  endtask

  task automatic ctrl_write(logic v, logic use_vda, logic use_vpa);
    load_bank(8'hFF);
    drive_high(16'hFFF0, 1'b0, use_vda, use_vpa, {7'b0, v});
    @(posedge clk);
    @(negedge clk); vda = 0; vpa = 0; rw = 1;
  endtask

  // expected pins from the address fields (R2, R3, R5, R6, R7, R8)
  task automatic sweep(logic ovl);
    for (int b = 0; b < 256; b++)
      for (int s = 0; s < 2; s++)
        for (int st = 0; st < 4; st++)
          for (int r = 0; r < 2; r++) begin
            logic [7:0] bb; logic d, p, mv, hit, memon;
            logic [1:0] g; logic [2:0] c; logic [6:0] blk;
            logic [2:0] eo, ew; logic [7:0] ec; logic er; logic [3:0] ei;
            bb = 8'(b); d = st[1]; p = st[0];
            g = bb[7:6]; c = bb[5:3]; blk = {bb[5:0], 1'(s)};
            mv = d | p; hit = ovl && bb == 8'h00;
            memon = mv && g != 2'd3 && !hit;
            eo = '1; ew = '1; ec = '1; ei = '1;
            if (memon) begin
              ec[c] = 1'b0;
              if (r == 1) eo[g] = 1'b0; else ew[g] = 1'b0;
            end
            er = !(mv && hit && r == 1);
            if (d && g == 2'd3 && blk < 7'd4) ei[blk[1:0]] = 1'b0;
            load_bank(bb);
            drive_high({1'(s), 15'h1234}, 1'(r), d, p, 8'hA5);
            chk("R3 grp_oe_n", {29'b0, grp_oe_n}, {29'b0, eo});
            chk("R3 grp_we_n", {29'b0, grp_we_n}, {29'b0, ew});
            chk("R5 chip_ce_n", {24'b0, chip_ce_n}, {24'b0, ec});
            chk("R8 rom_ce_n", {31'b0, rom_ce_n}, {31'b0, er});
            chk("R7 io_sel_n", {28'b0, io_sel_n}, {28'b0, ei});
          end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: no strobes, nothing selected (R6)
    chk("R6 reset ce", {24'b0, chip_ce_n}, 32'hFF);
    chk("R6 reset rom", {31'b0, rom_ce_n}, 32'h1);
    rst_n = 1'b1;

    // R8: overlay on after reset, bank 0 read goes to ROM
    load_bank(8'h00);
    drive_high(16'h0100, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R8 boot rom", {31'b0, rom_ce_n}, 32'h0);
    chk("R8 boot ram off", {24'b0, chip_ce_n}, 32'hFF);

    // R4: write with phi2 low keeps write enables high
    load_bank(8'h48);              // group 1, chip 1
    @(negedge clk); addr = 16'h0010; rw = 0; vda = 1; bus_d = 8'h48; #2;
    chk("R4 we low phase", {29'b0, grp_we_n}, 32'h7);
    chk("R5 ce low phase", {24'b0, chip_ce_n}, 32'hFD);
    drive_high(16'h0010, 1'b0, 1'b1, 1'b0, 8'h80);
    chk("R4 we high phase", {29'b0, grp_we_n}, 32'h5);

    // R1: bank held through high phase despite bus change
    @(negedge clk); rw = 1; bus_d = 8'hC0; #2;
    @(negedge clk); #2;
    chk("R1 hold oe", {29'b0, grp_oe_n}, 32'h5);
    chk("R1 hold ce", {24'b0, chip_ce_n}, 32'hFD);

    sweep(1'b1);

    // R9: vpa-only write to control leaves overlay on
    ctrl_write(1'b0, 1'b0, 1'b1);
    load_bank(8'h00);
    drive_high(16'h0200, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R9 vpa ignored", {31'b0, rom_ce_n}, 32'h0);

    // R9: vda write of 0 clears the overlay
    ctrl_write(1'b0, 1'b1, 1'b0);
    load_bank(8'h00);
    drive_high(16'h0200, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R9 cleared rom", {31'b0, rom_ce_n}, 32'h1);
    chk("R9 cleared ram", {24'b0, chip_ce_n}, 32'hFE);

    sweep(1'b0);

    // R9: writing 1 brings the overlay back
    ctrl_write(1'b1, 1'b1, 1'b0);
    load_bank(8'h00);
    drive_high(16'h0200, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R9 restored", {31'b0, rom_ce_n}, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule